// File: doc/BRIEF.md
# Reset-Window Register Write Protection

This block holds a small bank of configuration registers whose accidental change would upset the rest of the chip. Each register sits behind its own guard. After any reset, the block counts bus cycles. It lets a write reach a register only while the policy chosen for that register allows it. Under the window policy, writes pass during the early part of the run and are refused from then on until the next reset. Under the once-only policy, the first write after a reset passes at any time and every later write is refused.

A special-mode flag lifts every restriction, so test or boot firmware can rewrite the bank freely. The write port is a plain strobe with no back-pressure. A write is presented for one bus cycle and is either taken or silently dropped. The per-register enable shows the outcome in that same cycle. The register contents are always visible on a flat output bus.

Top module: `regwin_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every register reads RST_VAL (default 8'hFF) and no write enable is high.
- R2: A write to a window-policy register (policy bit 0) is taken when fewer than WINDOW (default 64) bus strobes have been seen since reset. A write on strobe index 63, counting from 0, is taken.
- R3: A write to a window-policy register on strobe index WINDOW or any later index is refused. The strobe count saturates and never wraps, so the window stays shut until the next reset.
- R4: A write counts only when wr_en and bus_cycle are both high. Only bus_cycle strobes advance the strobe count, and wr_en without bus_cycle changes nothing.
- R5: A once-only register (policy bit 1) takes the first write after reset whenever it comes, including after the window has closed. It refuses every later write.
- R6: The first accepted write to a once-only register uses up its single write even when the written data equals the current contents.
- R7: Any reset restores every register to RST_VAL, restarts the strobe count at zero and re-arms every once-only register.
- R8: While special_mode is high, every addressed write is taken, whatever the policy, the strobe count or earlier writes.
- R9: Register i answers only at address BASE_ADDR+i (default base 8'h38). A write to any other address changes no register and raises no enable. At most one enable is high in any cycle.
- R10: A refused write leaves the register unchanged and raises neither an enable nor any other indication.
- R11: When a write is taken, reg_we[i] is high in the same cycle, and reg_q slice i holds the new data from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cycle | input | 1 | Strobe marking one bus cycle |
| wr_en | input | 1 | Write request, qualified by bus_cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| policy_once | input | NUM_REGS | Per-register policy: 0 window, 1 once-only |
| special_mode | input | 1 | High lifts all protection |
| reg_we | output | NUM_REGS | Accepted-write enable per register, same cycle |
| reg_q | output | NUM_REGS*DATA_W | Register contents, register i at bits i*DATA_W upward |

## Verification
Suppose the strobe counter wraps or starts from the wrong value. A window register then accepts a write on index 64 or later, or refuses one on index 63. That shows on reg_we in the very cycle of the probing write. A once-only flag that is stuck, or that is not re-armed by reset, shows up at the second write after reset, or at the first write after a new reset, as a wrong reg_we. One cycle later it also shows as a wrong reg_q value. Wrong address decoding or a lost data path shows on reg_q one edge after the write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic {
    POL_WINDOW = 1'b0,
    POL_ONCE   = 1'b1
  } wprot_pol_e;
endpackage

// File: rtl/rw_cycle_counter.sv
module rw_cycle_counter #(
  parameter int WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic open_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

  logic [CW-1:0] cnt_q;

  // saturating count of bus strobes since reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick_i && (cnt_q != LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = (cnt_q < LIMIT);
endmodule

// File: rtl/rw_addr_decode.sv
module rw_addr_decode #(
  parameter int NUM_REGS  = 4,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h38
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(BASE_ADDR + i));
  end
endmodule

// File: rtl/rw_guard_slot.sv
module rw_guard_slot
  import regwin_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic              pol_i,
  input  logic              special_i,
  input  logic              win_open_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              we_o,
  output logic [DATA_W-1:0] q_o
);
  wprot_pol_e  pol;
  logic        used_q;
  logic        allow;
  logic [DATA_W-1:0] data_q;

  assign pol = wprot_pol_e'(pol_i);

  always_comb begin
    unique case (pol)
      POL_ONCE:   allow = !used_q;
      default:    allow = win_open_i;
    endcase
    we_o = hit_i && (special_i || allow);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= RST_VAL;
      used_q <= 1'b0;
    end else if (we_o) begin
      data_q <= wdata_i;
      if (pol == POL_ONCE) used_q <= 1'b1;
    end
  end

  assign q_o = data_q;
endmodule

// File: rtl/regwin_guard.sv
module regwin_guard #(
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h38,
  parameter int WINDOW    = 64,
  parameter logic [DATA_W-1:0] RST_VAL = '1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_cycle,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [NUM_REGS-1:0]        policy_once,
  input  logic                       special_mode,
  output logic [NUM_REGS-1:0]        reg_we,
  output logic [NUM_REGS*DATA_W-1:0] reg_q
);
  logic                win_open;
  logic [NUM_REGS-1:0] sel;
  logic                wr_go;

  assign wr_go = wr_en && bus_cycle;

  rw_cycle_counter #(.WINDOW(WINDOW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (bus_cycle),
    .open_o (win_open)
  );

  rw_addr_decode #(
    .NUM_REGS  (NUM_REGS),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .addr_i (wr_addr),
    .sel_o  (sel)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    rw_guard_slot #(
      .DATA_W  (DATA_W),
      .RST_VAL (RST_VAL)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (wr_go && sel[i]),
      .pol_i      (policy_once[i]),
      .special_i  (special_mode),
      .win_open_i (win_open),
      .wdata_i    (wr_data),
      .we_o       (reg_we[i]),
      .q_o        (reg_q[i*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/regwin_guard_chk.sv
module regwin_guard_chk #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  parameter int WINDOW   = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_cycle,
  input logic                       wr_en,
  input logic [NUM_REGS-1:0]        policy_once,
  input logic                       special_mode,
  input logic [NUM_REGS-1:0]        reg_we,
  input logic [NUM_REGS*DATA_W-1:0] reg_q
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

  logic [CW-1:0]       seen_q;
  logic [NUM_REGS-1:0] spent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      spent_q <= '0;
    end else begin
      if (bus_cycle && seen_q != LIMIT) seen_q <= seen_q + 1'b1;
      spent_q <= spent_q | (reg_we & policy_once);
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_we)); // R9

  AST_WE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we != '0) |-> (bus_cycle && wr_en)); // R4

  AST_WINDOW_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && seen_q == LIMIT) |-> ((reg_we & ~policy_once) == '0)); // R3

  AST_ONCE_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    !special_mode |-> ((reg_we & policy_once & spent_q) == '0)); // R5

  AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we == '0) |=> $stable(reg_q)); // R10
endmodule

bind regwin_guard regwin_guard_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .WINDOW   (WINDOW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_cycle    (bus_cycle),
  .wr_en        (wr_en),
  .policy_once  (policy_once),
  .special_mode (special_mode),
  .reg_we       (reg_we),
  .reg_q        (reg_q)
);

// File: tb/regwin_guard_tb_top.sv
module regwin_guard_tb_top;
  localparam int N    = 4;
  localparam int DW   = 8;
  localparam int BASE = 'h38;
  localparam int WIN  = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_cycle = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [N-1:0]  policy_once = 4'b1100;
  logic          special_mode = 1'b0;
  logic [N-1:0]  reg_we;
  logic [N*DW-1:0] reg_q;

  always #10 clk = ~clk; // 50 MHz

  regwin_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cycle(bus_cycle), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .policy_once(policy_once),
    .special_mode(special_mode), .reg_we(reg_we), .reg_q(reg_q)
  );

  typedef struct {
    logic [N-1:0]    we;
    logic [N*DW-1:0] q;
    string           tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] m_q [N];
  bit            m_used [N];
  int            m_cnt;

  function automatic logic [N*DW-1:0] pack_model();
    logic [N*DW-1:0] v;
    for (int i = 0; i < N; i++) v[i*DW +: DW] = m_q[i];
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_q[i] = 8'hFF;
      m_used[i] = 0;
    end
    m_cnt = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    bus_cycle = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  // driver: applies one bus op, pushes expectation, advances model
  task automatic op(input logic [7:0] a, input logic [DW-1:0] d,
                    input logic w, input logic b, input string tag);
    exp_t e;
    int idx;
    bit ok;
    wr_addr = a; wr_data = d; wr_en = w; bus_cycle = b;
    idx = int'(a) - BASE;
    e.we = '0;
    ok = 0;
    if (w && b && idx >= 0 && idx < N) begin
      if (special_mode) ok = 1;
      else if (policy_once[idx]) ok = !m_used[idx];
      else ok = (m_cnt < WIN);
      if (ok) e.we[idx] = 1'b1;
    end
    e.q = pack_model();
    e.tag = tag;
    sb.push_back(e);
    if (ok) begin
      m_q[idx] = d;
      if (policy_once[idx]) m_used[idx] = 1;
    end
    if (b && m_cnt < WIN) m_cnt++;
    @(negedge clk);
  endtask

  // monitor: samples mid low phase, compares against scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (reg_we !== e.we) begin
          errors++;
          $display("FAIL %s reg_we actual=%b expected=%b", e.tag, reg_we, e.we);
        end
        checks++;
        if (reg_q !== e.q) begin
          errors++;
          $display("FAIL %s reg_q actual=%h expected=%h", e.tag, reg_q, e.q);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    op(8'h00, 8'h00, 0, 1, "R1");                  // reset contents
    op(8'h38, 8'hA5, 1, 1, "R2");                  // early window write
    op(8'h00, 8'h00, 0, 1, "R11");                 // data visible next edge
    op(8'h39, 8'h5A, 1, 0, "R4");                  // wr without strobe
    op(8'h39, 8'h5A, 1, 0, "R4");
    op(8'h00, 8'h00, 0, 0, "R4");
    while (m_cnt < WIN - 1) op(8'h00, 8'h00, 0, 1, "R2");
    op(8'h39, 8'h63, 1, 1, "R2");                  // index 63 taken
    op(8'h38, 8'h64, 1, 1, "R3");                  // index 64 refused
    op(8'h00, 8'h00, 0, 1, "R10");
    for (int k = 0; k < 100; k++) op(8'h00, 8'h00, 0, 1, "R3");
    op(8'h38, 8'h11, 1, 1, "R3");                  // saturated, still shut
    op(8'h3A, 8'h3C, 1, 1, "R5");                  // once reg late first write
    op(8'h3A, 8'h77, 1, 1, "R5");                  // second refused
    op(8'h3B, 8'hFF, 1, 1, "R6");                  // equal data spends it
    op(8'h3B, 8'h11, 1, 1, "R6");
    op(8'h40, 8'h22, 1, 1, "R9");                  // outside range
    op(8'h37, 8'h22, 1, 1, "R9");
    op(8'h00, 8'h00, 0, 1, "R10");
    special_mode = 1'b1;
    op(8'h38, 8'hC3, 1, 1, "R8");
    op(8'h3A, 8'h81, 1, 1, "R8");
    op(8'h3A, 8'h82, 1, 1, "R8");
    op(8'h00, 8'h00, 0, 1, "R8");
    special_mode = 1'b0;
    do_reset();
    op(8'h00, 8'h00, 0, 1, "R7");                  // contents restored
    op(8'h3A, 8'h44, 1, 1, "R7");                  // re-armed once reg
    op(8'h38, 8'h55, 1, 1, "R7");                  // window reopened
    op(8'h3A, 8'h45, 1, 1, "R5");
    op(8'h00, 8'h00, 0, 1, "R11");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule